// File: doc/BRIEF.md
# Command-Block Device-to-Memory DMA Engine

This block is a single-channel DMA engine that moves bytes from a device into memory without the processor handling the data. Software does not program the transfer parameters as registers. It writes one pointer. The pointer gives the memory location of a two-word command block. The engine reads that block over its memory bus master port. The first word is the destination address and the second word is the byte count. The engine then stores one device byte per bus tenure, stepping the address up and the count down. When the count reaches zero it raises a completion interrupt.

The memory bus is addressed in locations. A byte written from the device fills one location, and each command word fills one location. The engine asks for the bus with `bus_req` and does not drive an address until it has sampled `bus_gnt` high. The arbiter must keep `bus_gnt` high for as long as `bus_req` stays high. Read data returns one cycle after the read strobe. During a fetch the engine holds the bus for both command words. For data it holds the bus for exactly one write per byte and then releases it, so the processor loses one bus cycle per byte.

The device side works as a valid/ready stream. `dev_req` is valid and `dev_ack` is ready. A byte moves in the cycle where both are high. The device must hold `dev_req` and `dev_data` steady until it sees `dev_ack`. The engine never raises `dev_ack` unless it also owns the bus and is writing that byte, so the stalls of the bus arbiter become back-pressure on the device.

Top module: `dma_cb_engine`

## Requirements
- R1: A pointer write (`host_we`=1, `host_sel`=0) accepted while idle or done starts a fetch. The engine reads location ptr as the destination address and location ptr+1 as the byte count, then reports that count on `stat_remaining`.
- R2: `mem_en` is asserted only while `bus_req` and `bus_gnt` are both high. While the grant is withheld the engine waits with `bus_req` high and makes no memory access.
- R3: Each device byte is taken with `dev_ack` in the same cycle as a memory write (`mem_en`=1, `mem_we`=1) of `dev_data` to the current destination address. Successive bytes land at consecutive locations starting at the fetched destination.
- R4: After each stored byte `stat_remaining` drops by exactly one.
- R5: When the count reaches zero `irq` goes high and `stat_phase` reads done (3) with `stat_remaining` zero.
- R6: A fetched count of zero finishes immediately with `irq` high. No device byte is taken and no memory write occurs.
- R7: `irq` stays high until a control write (`host_we`=1, `host_sel`=1) with `host_wdata` bit 0 set. A control write with bit 0 clear leaves it high.
- R8: A pointer write while fetching or transferring is ignored, and the running transfer completes unchanged. It sets `err`, which stays high until a control write with `host_wdata` bit 1 set.
- R9: While `dev_req` is low during a transfer the engine holds `bus_req` low and does not advance. `dev_ack` is never high without `dev_req`.
- R10: `stat_phase` encodes 0 idle, 1 fetching, 2 transferring, 3 done. Out of reset the engine is idle with `irq`, `err`, `bus_req` and `dev_ack` low. The phase reads fetching in the cycle after an accepted start.
- R11: `bus_req` is low in the cycle after every data write, so each byte costs a separate bus tenure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Host register write strobe |
| host_sel | input | 1 | 0 = command pointer (starts), 1 = control |
| host_wdata | input | AW | Pointer value, or control bits (bit 0 clear irq, bit 1 clear err) |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory location |
| mem_wdata | output | DW | Byte written to memory |
| mem_rdata | input | MW | Read data, valid one cycle after a read strobe |
| dev_req | input | 1 | Device byte valid |
| dev_data | input | DW | Device byte |
| dev_ack | output | 1 | Device byte taken (ready) |
| irq | output | 1 | Completion interrupt, sticky |
| err | output | 1 | Start-while-busy flag, sticky |
| stat_phase | output | 2 | Engine phase code |
| stat_remaining | output | CW | Bytes still to move |

## Verification
The main transfer is tried with a device that is held off and then streams without gaps. It is also tried with a device that runs dry partway through, which separates correct per-byte stepping from a count that is only right at the end. A zero-length block shows that completion is decided from the fetched count and not from device activity. A start issued mid-transfer shows that the pointer is ignored and only the error flag moves. Withholding the bus grant during the fetch shows that no address is driven before the grant. Fixed memory guard locations around each destination buffer reveal off-by-one addressing.

// File: rtl/dma_cb_pkg.sv
package dma_cb_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_XFER  = 2'd2,
    PH_DONE  = 2'd3
  } phase_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_F_REQ,
    ST_F_RD0,
    ST_F_RD1,
    ST_F_LAST,
    ST_X_WAIT,
    ST_X_REQ,
    ST_X_WR,
    ST_DONE
  } state_e;

  typedef enum logic [1:0] {
    AS_PTR0,
    AS_PTR1,
    AS_CUR
  } asel_e;

  function automatic phase_e phase_of(state_e s);
    case (s)
      ST_IDLE:                                   return PH_IDLE;
      ST_F_REQ, ST_F_RD0, ST_F_RD1, ST_F_LAST:   return PH_FETCH;
      ST_DONE:                                   return PH_DONE;
      default:                                   return PH_XFER;
    endcase
  endfunction

endpackage

// File: rtl/dma_cb_regs.sv
module dma_cb_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_we,
  input  logic       host_sel,
  input  logic [1:0] ctrl_bits,
  input  logic       busy,
  input  logic       done_pulse,
  output logic       start_ok,
  output logic       irq,
  output logic       err
);
  logic start_req, ctrl_wr;

  assign start_req = host_we && !host_sel;
  assign ctrl_wr   = host_we && host_sel;
  assign start_ok  = start_req && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq <= 1'b0;
      err <= 1'b0;
    end else begin
      if (done_pulse)                    irq <= 1'b1;
      else if (ctrl_wr && ctrl_bits[0])  irq <= 1'b0;
      if (start_req && busy)             err <= 1'b1;
      else if (ctrl_wr && ctrl_bits[1])  err <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_cb_ctrl.sv
module dma_cb_ctrl
  import dma_cb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start_ok,
  input  logic   bus_gnt,
  input  logic   dev_req,
  input  logic   cmd_cnt_zero,
  input  logic   last_byte,
  output logic   bus_req,
  output logic   mem_en,
  output logic   mem_we,
  output asel_e  addr_sel,
  output logic   ld_ptr,
  output logic   ld_addr,
  output logic   ld_cnt,
  output logic   step,
  output logic   dev_ack,
  output logic   busy,
  output logic   done_pulse,
  output phase_e phase
);
  state_e state, nxt;
  logic   wr_now;

  assign wr_now = (state == ST_X_WR) && dev_req;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE, ST_DONE: if (start_ok) nxt = ST_F_REQ;
      ST_F_REQ:  if (bus_gnt) nxt = ST_F_RD0;
      ST_F_RD0:  nxt = ST_F_RD1;
      ST_F_RD1:  nxt = ST_F_LAST;
      ST_F_LAST: nxt = cmd_cnt_zero ? ST_DONE : ST_X_WAIT;
      ST_X_WAIT: if (dev_req) nxt = ST_X_REQ;
      ST_X_REQ:  if (bus_gnt) nxt = ST_X_WR;
      ST_X_WR:   nxt = (wr_now && last_byte) ? ST_DONE : ST_X_WAIT;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    bus_req = (state == ST_F_REQ) || (state == ST_F_RD0) || (state == ST_F_RD1) ||
              (state == ST_F_LAST) || (state == ST_X_REQ) || (state == ST_X_WR);
    mem_en   = (state == ST_F_RD0) || (state == ST_F_RD1) || wr_now;
    mem_we   = wr_now;
    addr_sel = (state == ST_F_RD0) ? AS_PTR0 : (state == ST_F_RD1) ? AS_PTR1 : AS_CUR;
    ld_ptr   = start_ok;
    ld_addr  = (state == ST_F_RD1);
    ld_cnt   = (state == ST_F_LAST);
    step     = wr_now;
    dev_ack  = wr_now;
    busy     = (state != ST_IDLE) && (state != ST_DONE);
    done_pulse = ((state == ST_F_LAST) && cmd_cnt_zero) || (wr_now && last_byte);
    phase    = phase_of(state);
  end
endmodule

// File: rtl/dma_cb_datapath.sv
module dma_cb_datapath
  import dma_cb_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int MW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ptr_in,
  input  logic [MW-1:0] mem_rdata,
  input  asel_e         addr_sel,
  input  logic          ld_ptr,
  input  logic          ld_addr,
  input  logic          ld_cnt,
  input  logic          step,
  output logic [AW-1:0] mem_addr,
  output logic [CW-1:0] remaining,
  output logic          cmd_cnt_zero,
  output logic          last_byte
);
  localparam logic [AW-1:0] ONE_A = AW'(1);
  localparam logic [CW-1:0] ONE_C = CW'(1);

  logic [AW-1:0] ptr, cur;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr       <= '0;
      cur       <= '0;
      remaining <= '0;
    end else begin
      if (ld_ptr)  ptr <= ptr_in;
      if (ld_addr) cur <= mem_rdata[AW-1:0];
      else if (step) cur <= cur + ONE_A;
      if (ld_cnt)  remaining <= mem_rdata[CW-1:0];
      else if (step) remaining <= remaining - ONE_C;
    end
  end

  always_comb begin
    case (addr_sel)
      AS_PTR0: mem_addr = ptr;
      AS_PTR1: mem_addr = ptr + ONE_A;
      default: mem_addr = cur;
    endcase
  end

  assign cmd_cnt_zero = (mem_rdata[CW-1:0] == '0);
  assign last_byte    = (remaining == ONE_C);
endmodule

// File: rtl/dma_cb_engine.sv
module dma_cb_engine
  import dma_cb_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int MW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_we,
  input  logic          host_sel,
  input  logic [AW-1:0] host_wdata,
  output logic          bus_req,
  input  logic          bus_gnt,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [MW-1:0] mem_rdata,
  input  logic          dev_req,
  input  logic [DW-1:0] dev_data,
  output logic          dev_ack,
  output logic          irq,
  output logic          err,
  output logic [1:0]    stat_phase,
  output logic [CW-1:0] stat_remaining
);
  logic   start_ok, busy, done_pulse, ld_ptr, ld_addr, ld_cnt, step;
  logic   cmd_cnt_zero, last_byte;
  asel_e  addr_sel;
  phase_e phase;

  dma_cb_regs u_regs (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .ctrl_bits(host_wdata[1:0]), .busy(busy), .done_pulse(done_pulse),
    .start_ok(start_ok), .irq(irq), .err(err)
  );

  dma_cb_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .bus_gnt(bus_gnt),
    .dev_req(dev_req), .cmd_cnt_zero(cmd_cnt_zero), .last_byte(last_byte),
    .bus_req(bus_req), .mem_en(mem_en), .mem_we(mem_we), .addr_sel(addr_sel),
    .ld_ptr(ld_ptr), .ld_addr(ld_addr), .ld_cnt(ld_cnt), .step(step),
    .dev_ack(dev_ack), .busy(busy), .done_pulse(done_pulse), .phase(phase)
  );

  dma_cb_datapath #(.AW(AW), .CW(CW), .MW(MW)) u_dp (
    .clk(clk), .rst_n(rst_n), .ptr_in(host_wdata), .mem_rdata(mem_rdata),
    .addr_sel(addr_sel), .ld_ptr(ld_ptr), .ld_addr(ld_addr), .ld_cnt(ld_cnt),
    .step(step), .mem_addr(mem_addr), .remaining(stat_remaining),
    .cmd_cnt_zero(cmd_cnt_zero), .last_byte(last_byte)
  );

  assign mem_wdata  = dev_data;
  assign stat_phase = phase;
endmodule

// File: rtl/dma_cb_engine_chk.sv
module dma_cb_engine_chk #(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_we,
  input logic          host_sel,
  input logic [AW-1:0] host_wdata,
  input logic          bus_req,
  input logic          bus_gnt,
  input logic          mem_en,
  input logic          mem_we,
  input logic          dev_req,
  input logic          dev_ack,
  input logic          irq,
  input logic          err,
  input logic [1:0]    stat_phase,
  input logic [CW-1:0] stat_remaining
);
  a_r2_access_granted: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (bus_req && bus_gnt));

  a_r3_ack_with_write: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (mem_en && mem_we));

  a_r9_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> dev_req);

  a_r4_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> (stat_remaining == $past(stat_remaining) - CW'(1)));

  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we) |=> !bus_req);

  a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(host_we && host_sel && host_wdata[0])) |=> irq);

  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !(host_we && host_sel && host_wdata[1])) |=> err);

  a_r8_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && !host_sel && (stat_phase == 2'd1 || stat_phase == 2'd2)) |=> err);

  a_r5_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_phase == 2'd3) |-> (stat_remaining == '0));
endmodule

bind dma_cb_engine dma_cb_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
  .host_wdata(host_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
  .mem_en(mem_en), .mem_we(mem_we), .dev_req(dev_req), .dev_ack(dev_ack),
  .irq(irq), .err(err), .stat_phase(stat_phase), .stat_remaining(stat_remaining)
);

// File: tb/dma_cb_engine_test.sv
`timescale 1ns/1ps
module dma_cb_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, host_sel = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        bus_req, bus_gnt, mem_en, mem_we, dev_ack, irq, err;
  logic [15:0] mem_addr, mem_rdata, stat_remaining;
  logic [7:0]  mem_wdata, dev_data;
  logic        dev_req;
  logic [1:0]  stat_phase;

  always #2 clk = ~clk;

  dma_cb_engine uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_sel(host_sel),
    .host_wdata(host_wdata), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_req(dev_req), .dev_data(dev_data), .dev_ack(dev_ack),
    .irq(irq), .err(err), .stat_phase(stat_phase), .stat_remaining(stat_remaining)
  );

  int tests = 0, fails = 0, cycles = 0;
  logic [15:0] mem [256];
  logic arb_block = 1'b0;
  logic dev_en = 1'b0, dev_restart = 1'b0;
  int   dev_n = 0, dev_idx = 0;
  logic [7:0] dev_base = '0;
  int   ack_cnt = 0, rel_viol = 0, blk_viol = 0;
  logic prev_wr = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) bus_gnt <= 1'b0;
    else        bus_gnt <= bus_req && !arb_block;
    if (mem_en && !mem_we) mem_rdata <= mem[mem_addr[7:0]];
    if (mem_en && mem_we)  mem[mem_addr[7:0]] <= {8'h00, mem_wdata};
  end

  assign dev_req  = dev_en && (dev_idx < dev_n);
  assign dev_data = dev_base + 8'(dev_idx);

  always @(posedge clk) begin
    if (dev_restart) dev_idx <= 0;
    else if (dev_req && dev_ack) dev_idx <= dev_idx + 1;
    if (dev_ack) ack_cnt <= ack_cnt + 1;
    if (prev_wr && bus_req) rel_viol <= rel_viol + 1;
    if (arb_block && mem_en) blk_viol <= blk_viol + 1;
    prev_wr <= mem_en && mem_we;
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(logic sel, logic [15:0] val);
    @(negedge clk);
    host_we = 1'b1; host_sel = sel; host_wdata = val;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic dev_setup(logic [7:0] base, int n, logic en);
    @(negedge clk);
    dev_base = base; dev_n = n; dev_en = en; dev_restart = 1'b1;
    @(negedge clk);
    dev_restart = 1'b0;
  endtask

  task automatic wait_irq(int limit);
    for (int i = 0; i < limit && !irq; i++) @(negedge clk);
  endtask

  task automatic fill(int lo, int hi);
    for (int a = lo; a <= hi; a++) mem[a] = 16'h00EE;
  endtask

  task automatic t_reset;
    chk("R10 reset phase", stat_phase, 0);
    chk("R10 reset irq/err", {irq, err}, 0);
    chk("R10 reset bus_req/ack", {bus_req, dev_ack}, 0);
  endtask

  task automatic t_basic;
    int a0;
    mem[8'h10] = 16'h0040; mem[8'h11] = 16'd5;
    fill(8'h3F, 8'h46);
    dev_setup(8'h30, 5, 1'b0);
    a0 = ack_cnt;
    host_write(1'b0, 16'h0010);
    chk("R10 fetch phase after start", stat_phase, 1);
    repeat (12) @(negedge clk);
    chk("R1 count fetched", stat_remaining, 5);
    chk("R10 transfer phase", stat_phase, 2);
    chk("R9 no bus_req while device idle", bus_req, 0);
    chk("R9 no ack while device idle", ack_cnt - a0, 0);
    @(negedge clk); dev_en = 1'b1;
    wait_irq(200);
    for (int i = 0; i < 5; i++) chk("R3 byte stored", mem[8'h40 + i], 16'h30 + i);
    chk("R3 guard below", mem[8'h3F], 16'h00EE);
    chk("R3 guard above", mem[8'h45], 16'h00EE);
    chk("R5 irq", irq, 1);
    chk("R5 done phase", stat_phase, 3);
    chk("R5 remaining zero", stat_remaining, 0);
    chk("R11 bus released after each write", rel_viol, 0);
  endtask

  task automatic t_irq_hold;
    repeat (10) @(negedge clk);
    chk("R7 irq held", irq, 1);
    host_write(1'b1, 16'h0002);
    chk("R7 irq kept by bit0=0", irq, 1);
    host_write(1'b1, 16'h0001);
    chk("R7 irq cleared", irq, 0);
  endtask

  task automatic t_zero;
    int a0;
    mem[8'h20] = 16'h0060; mem[8'h21] = 16'd0;
    fill(8'h60, 8'h61);
    dev_setup(8'h11, 3, 1'b1);
    a0 = ack_cnt;
    host_write(1'b0, 16'h0020);
    wait_irq(50);
    repeat (3) @(negedge clk);
    chk("R6 irq on zero count", irq, 1);
    chk("R6 phase done", stat_phase, 3);
    chk("R6 no ack", ack_cnt - a0, 0);
    chk("R6 no write", mem[8'h60], 16'h00EE);
    host_write(1'b1, 16'h0001);
  endtask

  task automatic t_partial;
    mem[8'h30] = 16'h0070; mem[8'h31] = 16'd4;
    fill(8'h70, 8'h74);
    dev_setup(8'h50, 2, 1'b1);
    host_write(1'b0, 16'h0030);
    repeat (40) @(negedge clk);
    chk("R4 remaining after two bytes", stat_remaining, 2);
    chk("R9 waits for device", stat_phase, 2);
    chk("R4 no irq mid transfer", irq, 0);
    @(negedge clk); dev_n = 4;
    wait_irq(200);
    for (int i = 0; i < 4; i++) chk("R4 byte stored", mem[8'h70 + i], 16'h50 + i);
    chk("R4 guard above", mem[8'h74], 16'h00EE);
    host_write(1'b1, 16'h0001);
  endtask

  task automatic t_busy_start;
    mem[8'h38] = 16'h0080; mem[8'h39] = 16'd3;
    mem[8'h3A] = 16'h00A0; mem[8'h3B] = 16'd2;
    fill(8'h80, 8'h83); fill(8'hA0, 8'hA1);
    dev_setup(8'h70, 3, 1'b0);
    host_write(1'b0, 16'h0038);
    repeat (12) @(negedge clk);
    host_write(1'b0, 16'h003A);
    chk("R8 err set", err, 1);
    chk("R8 count unchanged", stat_remaining, 3);
    @(negedge clk); dev_en = 1'b1;
    wait_irq(200);
    for (int i = 0; i < 3; i++) chk("R8 first transfer intact", mem[8'h80 + i], 16'h70 + i);
    chk("R8 second pointer ignored", mem[8'hA0], 16'h00EE);
    host_write(1'b1, 16'h0002);
    chk("R8 err cleared", err, 0);
    chk("R7 irq untouched by err clear", irq, 1);
    host_write(1'b1, 16'h0001);
  endtask

  task automatic t_grant;
    int a0;
    mem[8'h10] = 16'h0040; mem[8'h11] = 16'd5;
    dev_setup(8'h90, 5, 1'b1);
    a0 = ack_cnt;
    @(negedge clk); arb_block = 1'b1;
    host_write(1'b0, 16'h0010);
    repeat (15) @(negedge clk);
    chk("R2 request held", bus_req, 1);
    chk("R2 still fetching", stat_phase, 1);
    chk("R2 no access without grant", blk_viol, 0);
    chk("R2 no ack without grant", ack_cnt - a0, 0);
    arb_block = 1'b0;
    wait_irq(200);
    chk("R2 transfer after grant", mem[8'h44], 16'h0094);
    chk("R5 done after grant", stat_phase, 3);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) mem[a] = '0;
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_basic();
    t_irq_hold();
    t_zero();
    t_partial();
    t_busy_start();
    t_grant();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule